// File: doc/BRIEF.md
# Status-Polled Flash Bank Programmer

This controller erases or programs one bank of a byte-wide parallel flash device that is driven through a command-and-status protocol. A host pulses one start input to choose the operation. An erase sends a two-command sequence to the bank base. Programming fetches each byte from the host through a ready/valid handshake and writes it as a two-write command: a setup opcode, a settle delay, then the data. After every write operation the controller polls the device by issuing a status-read command and then reading the base address, until bit 7 of the status byte comes back set.

When the erase or the programming run ends, the controller sends a fixed two-command cleanup that puts the device back into array-read mode. It then reads back every address of the bank. Each byte is compared against 0xFF after an erase. After programming, each byte is compared against the expected data, which the controller requests from the host a second time through the same handshake. The result is reported through sticky flags: poll timeout, readback mismatch and latched device error bits. A combined fail output and a one-cycle done pulse complete the report. The bank size, the settle delay (given in nanoseconds with the clock frequency) and the poll attempt limit are all parameters.

Top module: `flash_bank_prog`

## Requirements
- R1: An erase writes 0x20 and then 0xD0 to address 0 as its first two bus writes, and then polls.
- R2: Each poll attempt writes 0x70 to address 0 and reads address 0 in the next cycle. The read data is taken one cycle after the read strobe, and the operation completes when bit 7 of that byte is 1. A device that needs k busy polls produces exactly k+1 status-command writes.
- R3: Programming handles addresses in ascending order from 0. For each address it writes 0x40, then writes the data byte to the same address no earlier than SETTLE_CYC+1 cycles later, then polls. SETTLE_CYC is the settle time in nanoseconds times the clock frequency, with a minimum of 1.
- R4: A poll sequence performs at most POLL_LIMIT status reads. If none shows bit 7 set, `timed_out` is set and, in programming, no further address is fetched or written.
- R5: Every erase or programming run, including one that timed out, ends its writes with 0x50 and then 0xFF at address 0.
- R6: After an erase, every address is read back. Any byte other than 0xFF sets `verify_bad`. An erase uses no handshake transfers.
- R7: After programming, the bytes are requested again from address 0 upward and every address is compared with its readback. Any difference sets `verify_bad`. A full run makes 2×2^ADDR_W transfers, and a run that timed out on the first byte makes 1+2^ADDR_W.
- R8: At each completed poll, status bits 5:3 are ORed into `err_bits`. `fail` is high when `timed_out`, `verify_bad` or any `err_bits` bit is set, even if the readback matched.
- R9: `busy` is high from the cycle after an accepted start until `done`, and `done` is a single-cycle pulse. The flags clear when a start is accepted. A start while busy is ignored. If both starts arrive together, erase is taken.
- R10: A byte is taken only in a cycle where both `byte_ready` and `byte_valid` are high. `byte_addr` gives the address of the byte being requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_erase | input | 1 | Start an erase (taken when idle) |
| start_prog | input | 1 | Start a programming run (taken when idle) |
| byte_ready | output | 1 | Controller wants the byte at `byte_addr` |
| byte_valid | input | 1 | Host presents a byte |
| byte_data | input | 8 | Byte from the host |
| byte_addr | output | ADDR_W | Bank address of the requested byte |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timed_out | output | 1 | Sticky: a poll sequence gave up |
| verify_bad | output | 1 | Sticky: readback mismatch |
| err_bits | output | 3 | Sticky OR of status bits 5:3 |
| fail | output | 1 | Any failure flag set |

## Verification
Erase runs are tried against a device that completes on the first status read and against one that stays busy for several reads. The resulting count of status-command writes shows whether bit 7 is really tested and whether a busy reply leads to a retry. Programming runs use four data patterns: one that differs at every address, an address ramp, all zeros and a mixed pattern. Some of these runs use a host that withholds valid every other cycle, which separates a correct handshake from one that takes data without `byte_valid`. A device that never becomes ready tells the timeout path apart from the normal path and shows that remaining bytes are skipped. Injected status error bits and a stuck data bit separate the sticky error latch from the readback compare.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERS_SETUP,
    ST_ERS_GO,
    ST_PRG_FETCH,
    ST_PRG_SETUP,
    ST_PRG_WAIT,
    ST_PRG_DATA,
    ST_POLL_CMD,
    ST_POLL_RD,
    ST_POLL_CHK,
    ST_CLR,
    ST_RST,
    ST_VFY_FETCH,
    ST_VFY_RD,
    ST_VFY_CMP,
    ST_FINISH
  } fbp_state_e;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_CLR_STATUS  = 8'h50;
  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] ERASED_BYTE    = 8'hFF;

  localparam int STAT_READY_BIT = 7;
  localparam int STAT_ERR_LSB   = 3;
  localparam int STAT_ERR_W     = 3;

endpackage

// File: rtl/fbp_rst_sync.sv
module fbp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/fbp_countdown.sv
// Settle-delay down-counter: loads a value, then counts to zero.
module fbp_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/fbp_poll_ctr.sv
// Counts status attempts in one poll sequence; flags the final allowed one.
module fbp_poll_ctr #(
  parameter int LIMIT = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int PW = $clog2(LIMIT + 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (bump) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q >= PW'(LIMIT - 1));
endmodule

// File: rtl/fbp_addr_ctr.sv
module fbp_addr_ctr #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] addr,
  output logic         at_last
);
  logic [W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (clear)    addr_d = '0;
    else if (inc) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr    = addr_q;
  assign at_last = &addr_q;
endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog #(
  parameter int ADDR_W     = 13,
  parameter int CLK_HZ     = 100_000_000,
  parameter int SETTLE_NS  = 1000,
  parameter int POLL_LIMIT = 1_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_erase,
  input  logic              start_prog,
  output logic              byte_ready,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata,
  output logic              busy,
  output logic              done,
  output logic              timed_out,
  output logic              verify_bad,
  output logic [2:0]        err_bits,
  output logic              fail
);
  import fbp_pkg::*;

  localparam int SETTLE_RAW = (CLK_HZ / 1000) * SETTLE_NS / 1_000_000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int TW         = $clog2(SETTLE_CYC + 1);

  logic rst_sn;

  fbp_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_sn)
  );

  fbp_state_e state_q, state_d;
  logic       mode_prog_q, mode_prog_d;
  logic [7:0] dat_q, exp_q;
  logic       to_q, bad_q;
  logic [STAT_ERR_W-1:0] err_q;

  // control strobes from the next-state logic
  logic take, dat_ld, exp_ld, to_set, bad_set, err_or;
  logic addr_clr, addr_inc, tmr_ld, tmr_dec, poll_clr, poll_bump;
  logic tmr_zero, poll_last, addr_last;
  logic [ADDR_W-1:0] addr;

  fbp_countdown #(.W(TW)) u_settle (
    .clk     (clk),
    .rst_n   (rst_sn),
    .load    (tmr_ld),
    .load_val(TW'(SETTLE_CYC - 1)),
    .dec     (tmr_dec),
    .zero    (tmr_zero)
  );

  fbp_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk  (clk),
    .rst_n(rst_sn),
    .clear(poll_clr),
    .bump (poll_bump),
    .last (poll_last)
  );

  fbp_addr_ctr #(.W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_sn),
    .clear  (addr_clr),
    .inc    (addr_inc),
    .addr   (addr),
    .at_last(addr_last)
  );

  // Next-state and bus control
  always_comb begin
    state_d     = state_q;
    mode_prog_d = mode_prog_q;
    fl_we       = 1'b0;
    fl_re       = 1'b0;
    fl_wdata    = 8'h00;
    fl_addr     = '0;
    byte_ready  = 1'b0;
    take        = 1'b0;
    dat_ld      = 1'b0;
    exp_ld      = 1'b0;
    to_set      = 1'b0;
    bad_set     = 1'b0;
    err_or      = 1'b0;
    addr_clr    = 1'b0;
    addr_inc    = 1'b0;
    tmr_ld      = 1'b0;
    tmr_dec     = 1'b0;
    poll_clr    = 1'b0;
    poll_bump   = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        // R9: erase has priority when both starts arrive together
        if (start_erase) begin
          take = 1'b1; mode_prog_d = 1'b0; addr_clr = 1'b1;
          state_d = ST_ERS_SETUP;
        end else if (start_prog) begin
          take = 1'b1; mode_prog_d = 1'b1; addr_clr = 1'b1;
          state_d = ST_PRG_FETCH;
        end
      end
      ST_ERS_SETUP: begin
        fl_we = 1'b1; fl_wdata = OP_ERASE_SETUP;
        state_d = ST_ERS_GO;
      end
      ST_ERS_GO: begin
        fl_we = 1'b1; fl_wdata = OP_ERASE_GO;
        poll_clr = 1'b1;
        state_d = ST_POLL_CMD;
      end
      ST_PRG_FETCH: begin
        byte_ready = 1'b1;
        if (byte_valid) begin
          dat_ld = 1'b1;
          state_d = ST_PRG_SETUP;
        end
      end
      ST_PRG_SETUP: begin
        fl_we = 1'b1; fl_wdata = OP_PROG_SETUP; fl_addr = addr;
        tmr_ld = 1'b1;
        state_d = ST_PRG_WAIT;
      end
      ST_PRG_WAIT: begin
        if (tmr_zero) state_d = ST_PRG_DATA;
        else          tmr_dec = 1'b1;
      end
      ST_PRG_DATA: begin
        fl_we = 1'b1; fl_wdata = dat_q; fl_addr = addr;
        poll_clr = 1'b1;
        state_d = ST_POLL_CMD;
      end
      ST_POLL_CMD: begin
        fl_we = 1'b1; fl_wdata = OP_STATUS;
        state_d = ST_POLL_RD;
      end
      ST_POLL_RD: begin
        fl_re = 1'b1;
        state_d = ST_POLL_CHK;
      end
      ST_POLL_CHK: begin
        if (fl_rdata[STAT_READY_BIT]) begin
          err_or = 1'b1;
          if (mode_prog_q && !addr_last) begin
            addr_inc = 1'b1;
            state_d = ST_PRG_FETCH;
          end else begin
            state_d = ST_CLR;
          end
        end else if (poll_last) begin
          to_set = 1'b1;
          state_d = ST_CLR;
        end else begin
          poll_bump = 1'b1;
          state_d = ST_POLL_CMD;
        end
      end
      ST_CLR: begin
        fl_we = 1'b1; fl_wdata = OP_CLR_STATUS;
        state_d = ST_RST;
      end
      ST_RST: begin
        fl_we = 1'b1; fl_wdata = OP_READ_ARRAY;
        addr_clr = 1'b1;
        state_d = ST_VFY_FETCH;
      end
      ST_VFY_FETCH: begin
        if (mode_prog_q) begin
          byte_ready = 1'b1;
          if (byte_valid) begin
            exp_ld = 1'b1;
            state_d = ST_VFY_RD;
          end
        end else begin
          exp_ld = 1'b1;
          state_d = ST_VFY_RD;
        end
      end
      ST_VFY_RD: begin
        fl_re = 1'b1; fl_addr = addr;
        state_d = ST_VFY_CMP;
      end
      ST_VFY_CMP: begin
        if (fl_rdata != exp_q) bad_set = 1'b1;
        if (addr_last) begin
          state_d = ST_FINISH;
        end else begin
          addr_inc = 1'b1;
          state_d = ST_VFY_FETCH;
        end
      end
      ST_FINISH: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q     <= ST_IDLE;
      mode_prog_q <= 1'b0;
      dat_q       <= 8'h00;
      exp_q       <= 8'h00;
      to_q        <= 1'b0;
      bad_q       <= 1'b0;
      err_q       <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        mode_prog_q <= mode_prog_d;
        to_q        <= 1'b0;
        bad_q       <= 1'b0;
        err_q       <= '0;
      end else begin
        if (to_set)  to_q  <= 1'b1;
        if (bad_set) bad_q <= 1'b1;
        if (err_or)  err_q <= err_q | fl_rdata[STAT_ERR_LSB +: STAT_ERR_W];
      end
      if (dat_ld) dat_q <= byte_data;
      if (exp_ld) exp_q <= mode_prog_q ? byte_data : ERASED_BYTE;
    end
  end

  assign byte_addr  = addr;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FINISH);
  assign timed_out  = to_q;
  assign verify_bad = bad_q;
  assign err_bits   = err_q;
  assign fail       = to_q | bad_q | (|err_q);
endmodule

// File: rtl/fbp_prog_chk.sv
module fbp_prog_chk #(
  parameter int SETTLE_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       fl_we,
  input logic       fl_re,
  input logic [7:0] fl_wdata,
  input logic       byte_ready,
  input logic       timed_out,
  input logic       verify_bad
);
  localparam int GW = $clog2(SETTLE_CYC + 2) + 1;

  logic          armed_q;
  logic [GW-1:0] gap_q;

  // R3: cycles since a program-setup write, checked at the data write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else if (fl_we && armed_q) begin
      a_r3_settle_gap: assert (gap_q >= GW'(SETTLE_CYC))
        else $error("data write %0d cycles after setup", gap_q);
      armed_q <= 1'b0;
    end else if (fl_we && fl_wdata == 8'h40) begin
      armed_q <= 1'b1;
      gap_q   <= '0;
    end else if (gap_q != {GW{1'b1}}) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_we && !fl_re && !byte_ready));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  a_r10_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (!fl_we && !fl_re));

  a_r4_timeout_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> busy);

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(timed_out) && $stable(verify_bad)));
endmodule

bind flash_bank_prog fbp_prog_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .busy      (busy),
  .done      (done),
  .fl_we     (fl_we),
  .fl_re     (fl_re),
  .fl_wdata  (fl_wdata),
  .byte_ready(byte_ready),
  .timed_out (timed_out),
  .verify_bad(verify_bad)
);

// File: tb/flash_bank_prog_tb.sv
module flash_bank_prog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW     = 5;
  localparam int NBYTES = 1 << AW;
  localparam int LIMIT  = 6;
  localparam int SETTLE = 4;   // 4 MHz clock, 1000 ns settle

  typedef struct packed {
    logic       prog;
    logic [1:0] pat;
    logic [2:0] bpoll;
    logic       stuck;
    logic [2:0] inj;
    logic       corrupt;
    logic       stall;
    logic       exp_to;
    logic       exp_bad;
    logic [2:0] exp_err;
    logic [9:0] exp_wr;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 2'd0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 10'd5},
    '{1'b0, 2'd0, 3'd3, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 10'd8},
    '{1'b1, 2'd0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 10'd98},
    '{1'b1, 2'd1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 10'd162},
    '{1'b1, 2'd2, 3'd1, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 10'd130},
    '{1'b0, 2'd0, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 10'd10},
    '{1'b1, 2'd0, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 10'd10},
    '{1'b0, 2'd0, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 10'd5},
    '{1'b1, 2'd3, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 10'd98},
    '{1'b0, 2'd0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 10'd5}
  };

  logic clk, rst_n, start_erase, start_prog;
  logic byte_ready, byte_valid;
  logic [7:0] byte_data;
  logic [AW-1:0] byte_addr, fl_addr;
  logic [7:0] fl_wdata, fl_rdata;
  logic fl_we, fl_re, busy, done, timed_out, verify_bad, fail;
  logic [2:0] err_bits;

  flash_bank_prog #(
    .ADDR_W(AW), .CLK_HZ(4_000_000), .SETTLE_NS(1000), .POLL_LIMIT(LIMIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_erase(start_erase), .start_prog(start_prog),
    .byte_ready(byte_ready), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_addr(byte_addr), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we),
    .fl_re(fl_re), .fl_rdata(fl_rdata), .busy(busy), .done(done),
    .timed_out(timed_out), .verify_bad(verify_bad), .err_bits(err_bits), .fail(fail)
  );

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat_byte(input logic [1:0] p, input logic [7:0] i);
    case (p)
      2'd0:    return 8'hA5 ^ i;
      2'd1:    return i;
      2'd2:    return 8'h00;
      default: return {i[2:0], i[4:0]} ^ 8'h3C;
    endcase
  endfunction

  // host data source
  logic [1:0] cur_pat;
  logic       src_en, stall_en, stall_ph;
  assign byte_data  = pat_byte(cur_pat, 8'(byte_addr));
  assign byte_valid = src_en && (!stall_en || stall_ph);
  always @(negedge clk) stall_ph <= ~stall_ph;

  // flash device model and bus log
  logic [7:0] mem [NBYTES];
  logic [7:0] wr_d [1024];
  logic [AW-1:0] wr_a [1024];
  int  wr_n, hs_n, bad_poll_addr, settle_viol, setup_cyc, busy_left;
  logic prg_armed, ers_armed, stat_mode;
  logic m_stuck, m_corrupt;
  logic [2:0] m_inj;
  int  m_bpoll;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (byte_ready && byte_valid) hs_n = hs_n + 1;
    if (fl_we) begin
      if (wr_n < 1024) begin wr_d[wr_n] = fl_wdata; wr_a[wr_n] = fl_addr; end
      wr_n = wr_n + 1;
      if (prg_armed) begin
        if (cyc - setup_cyc < SETTLE + 1) settle_viol = settle_viol + 1;
        mem[fl_addr] = (m_corrupt && fl_addr == 7) ? (fl_wdata ^ 8'h01) : fl_wdata;
        prg_armed = 1'b0;
        busy_left = m_bpoll;
      end else begin
        case (fl_wdata)
          8'h40: begin prg_armed = 1'b1; setup_cyc = cyc; end
          8'h20: ers_armed = 1'b1;
          8'hD0: if (ers_armed) begin
                   for (int k = 0; k < NBYTES; k++) mem[k] = 8'hFF;
                   if (m_corrupt) mem[3] = 8'h7F;
                   busy_left = m_bpoll;
                 end
          8'h70: stat_mode = 1'b1;
          8'hFF: stat_mode = 1'b0;
          default: ;
        endcase
        if (fl_wdata != 8'h20) ers_armed = 1'b0;
      end
    end
    if (fl_re) begin
      if (stat_mode) begin
        if (fl_addr != '0) bad_poll_addr = bad_poll_addr + 1;
        if (!m_stuck && busy_left == 0) fl_rdata <= {1'b1, 1'b0, m_inj, 3'b000};
        else begin
          fl_rdata <= 8'h00;
          if (busy_left > 0) busy_left = busy_left - 1;
        end
      end else begin
        fl_rdata <= mem[fl_addr];
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 150_000) begin
      n_err = n_err + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: run did not finish (act=%0d exp<%0d cycles)", cyc, 150_000);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_err = n_err + 1;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_n = 0; hs_n = 0; bad_poll_addr = 0; settle_viol = 0;
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic seen;
    int mism, exp_hs;
    m_stuck = v.stuck; m_corrupt = v.corrupt; m_inj = v.inj; m_bpoll = int'(v.bpoll);
    cur_pat = v.pat; stall_en = v.stall; src_en = 1'b1;
    clear_log();
    if (v.prog) start_prog = 1'b1; else start_erase = 1'b1;
    @(negedge clk);
    start_prog = 1'b0; start_erase = 1'b0;
    // R9: flags cleared and busy raised once the start is taken
    chk(busy && !fail, "R9", "busy/flags after start", {busy, fail}, 2'b10);
    wait_done(seen);
    chk(seen, "R9", "done pulse seen", seen, 1);
    chk(timed_out == v.exp_to, "R4", "timed_out", timed_out, v.exp_to);
    chk(verify_bad == v.exp_bad, v.prog ? "R7" : "R6", "verify_bad", verify_bad, v.exp_bad);
    chk(err_bits == v.exp_err, "R8", "err_bits", err_bits, v.exp_err);
    chk(fail == (v.exp_to | v.exp_bad | (|v.exp_err)), "R8", "fail", fail,
        v.exp_to | v.exp_bad | (|v.exp_err));
    chk(wr_n == int'(v.exp_wr), "R2", "write count (R4 skip)", wr_n, v.exp_wr);
    chk(bad_poll_addr == 0, "R2", "status read off base", bad_poll_addr, 0);
    if (v.prog) begin
      chk(wr_d[0] == 8'h40 && wr_a[0] == 0, "R3", "setup write", wr_d[0], 8'h40);
      chk(wr_d[1] == pat_byte(v.pat, 8'h00) && wr_a[1] == 0, "R3", "data write",
          wr_d[1], pat_byte(v.pat, 8'h00));
      chk(settle_viol == 0, "R3", "settle gap violations", settle_viol, 0);
      exp_hs = v.exp_to ? 1 + NBYTES : 2 * NBYTES;
    end else begin
      chk(wr_d[0] == 8'h20 && wr_d[1] == 8'hD0 && wr_a[0] == 0 && wr_a[1] == 0,
          "R1", "erase commands", {wr_d[0], wr_d[1]}, 16'h20D0);
      exp_hs = 0;
    end
    chk(hs_n == exp_hs, "R10", "handshake count (R7)", hs_n, exp_hs);
    chk(wr_d[wr_n-2] == 8'h50 && wr_d[wr_n-1] == 8'hFF && wr_a[wr_n-2] == 0
        && wr_a[wr_n-1] == 0, "R5", "cleanup writes",
        {wr_d[wr_n-2], wr_d[wr_n-1]}, 16'h50FF);
    if (!v.exp_to && !v.corrupt) begin
      mism = 0;
      for (int k = 0; k < NBYTES; k++)
        if (mem[k] != (v.prog ? pat_byte(v.pat, 8'(k)) : 8'hFF)) mism = mism + 1;
      chk(mism == 0, v.prog ? "R3" : "R6", "bank contents", mism, 0);
    end
    @(negedge clk);
    chk(!done, "R9", "done one cycle", done, 0);
    src_en = 1'b0;
  endtask

  initial begin
    logic seen;
    int n20;
    rst_n = 1'b0; start_erase = 1'b0; start_prog = 1'b0;
    src_en = 1'b0; stall_en = 1'b0; stall_ph = 1'b0; cur_pat = 2'd0;
    fl_rdata = 8'h00; prg_armed = 1'b0; ers_armed = 1'b0; stat_mode = 1'b0;
    m_stuck = 1'b0; m_corrupt = 1'b0; m_inj = 3'd0; m_bpoll = 0; busy_left = 0;
    setup_cyc = 0;
    for (int k = 0; k < NBYTES; k++) mem[k] = 8'h00;
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    chk(!busy && !done, "R9", "idle after reset", {busy, done}, 0);
    chk(!fl_we && !fl_re && !byte_ready, "R9", "bus quiet after reset",
        {fl_we, fl_re, byte_ready}, 0);
    chk(!fail && err_bits == 0, "R8", "flags after reset", {fail, err_bits}, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R9: start_erase during a program run is ignored
    m_stuck = 1'b0; m_corrupt = 1'b0; m_inj = 3'd0; m_bpoll = 0;
    cur_pat = 2'd1; stall_en = 1'b0; src_en = 1'b1;
    clear_log();
    start_prog = 1'b1;
    @(negedge clk);
    start_prog = 1'b0;
    repeat (20) @(negedge clk);
    start_erase = 1'b1;
    @(negedge clk);
    start_erase = 1'b0;
    wait_done(seen);
    n20 = 0;
    for (int k = 0; k < wr_n && k < 1024; k++) if (wr_d[k] == 8'h20) n20 = n20 + 1;
    chk(seen && n20 == 0, "R9", "erase start ignored while busy", n20, 0);
    chk(hs_n == 2 * NBYTES && !fail, "R9", "program unaffected", hs_n, 2 * NBYTES);
    @(negedge clk);
    src_en = 1'b0;

    // R9: both starts together, erase taken
    clear_log();
    start_prog = 1'b1; start_erase = 1'b1;
    @(negedge clk);
    start_prog = 1'b0; start_erase = 1'b0;
    wait_done(seen);
    chk(seen && wr_d[0] == 8'h20 && hs_n == 0, "R9", "erase priority", wr_d[0], 8'h20);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule